// File: doc/BRIEF.md
# Serial Flash Range Erase Sequencer

This block turns one erase request, given as a byte start address and a byte length, into the series of serial flash commands that clears that range. It first divides both numbers by the page size, which may be any value and need not be a power of two. If either division leaves a remainder, it refuses the request. Otherwise it walks the range one step at a time. At each step it picks an eight-page block erase or a single-page erase and builds the four-byte command. It then polls the device status until the device is ready.

The command side talks to a byte shifter that carries one byte at a time. The sequencer presents a byte and holds it until the shifter answers with a completion strobe. With that strobe come the byte shifted in and a transfer-failure flag. Chip select is low only while a frame is in progress. It is forced high for at least one cycle between frames, and for a programmable gap between status polls that report busy. The device address is the page index shifted left by a per-device page-offset amount, not a linear byte address.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start address or length is not an exact multiple of `page_size` is answered by a one-cycle `err` pulse. No frame is sent (chip select stays high).
- R2: The opcode is 0x50 (block erase) when the current page index has bits [2:0] equal to zero and at least eight pages remain. Otherwise it is 0x81 (page erase).
- R3: An erase frame is exactly four bytes: the opcode, device address bits [23:16], device address bits [15:8], then 0x00. `tx_last` is high only on the fourth byte. The device address is the page index shifted left by `page_shift`, truncated to 24 bits.
- R4: After each erase frame, two-byte status frames (0xD7 then 0x00, `tx_last` on the second byte) are repeated until bit 7 of the byte returned with the second byte is 1 and that byte reported no failure. Chip select returns high after every frame.
- R5: After a status frame that reports busy, chip select stays high for at least `poll_gap` cycles before the next status frame starts.
- R6: After a ready status, the page index advances and the remaining page count drops by 8 after a block erase, or by 1 after a page erase.
- R7: If any byte of an erase frame completes with `tx_err` high, the sequencer still polls to ready. It then resends the same command without advancing.
- R8: `done` pulses for exactly one cycle two cycles after the completion strobe of the final ready status byte. A zero-length aligned request gives `done` with no frame.
- R9: `req_ready` is high only when idle. It drops the cycle after a request is accepted and stays low until `done` or `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle; a request is taken on valid and ready |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| page_size | input | PS_W | Bytes per page (non-zero) |
| page_shift | input | SH_W | Left shift from page index to device address |
| poll_gap | input | GAP_W | Minimum idle cycles between busy status polls |
| cs_n | output | 1 | Chip select, active low |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_byte | output | 8 | Byte to send |
| tx_last | output | 1 | Offered byte ends the frame |
| tx_done | input | 1 | Shifter finished the offered byte |
| tx_err | input | 1 | Transfer of that byte failed |
| rx_byte | input | 8 | Byte shifted in with that byte |
| done | output | 1 | One-cycle pulse: range erased |
| err | output | 1 | One-cycle pulse: request misaligned |

## Verification
The bench plays the shifter. It returns each completion strobe a fixed number of cycles after a byte is offered. It logs the erase commands, measures the idle time between polls, and stamps the cycle of each completion strobe. `done` is due exactly two sampled cycles after the final ready status strobe, and the bench checks that distance rather than merely waiting for the pulse. `req_ready` must be low in the cycle after acceptance. The divide result (`err`, or `done` for zero length) arrives about ADDR_W plus two cycles after acceptance, so those outcomes are awaited under a bound. The logged commands are compared one by one with a list the bench builds from the page index, remaining count, shift and injected failure.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV,
        S_ECMD,
        S_SEP,
        S_POLL,
        S_WAIT,
        S_STEP
    } seq_state_e;

    localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OP_STATUS      = 8'hD7;
    localparam int         READY_BIT      = 7;
    localparam int         DEV_ADDR_W     = 24;

endpackage

// File: rtl/erase_div.sv
// Iterative restoring divider: one quotient bit per cycle.
module erase_div #(
    parameter int W  = 24,
    parameter int DW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [W-1:0]  quot,
    output logic [W-1:0]  remn
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W-1:0]  q;
        logic [W-1:0]  r;
        logic [W:0]    dvs;
        logic          done;
    } div_t;

    div_t div_d, div_q;
    logic [W:0] trial;
    logic [W:0] diff;
    logic       ge;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = {div_q.r, div_q.q[W-1]};
        ge         = (trial >= div_q.dvs);
        diff       = trial - div_q.dvs;
        if (start) begin
            div_d.run = 1'b1;
            div_d.cnt = '0;
            div_d.q   = dividend;
            div_d.r   = '0;
            div_d.dvs = {{(W + 1 - DW){1'b0}}, divisor};
        end else if (div_q.run) begin
            div_d.r   = ge ? diff[W-1:0] : trial[W-1:0];
            div_d.q   = {div_q.q[W-2:0], ge};
            div_d.cnt = div_q.cnt + 1'b1;
            if (div_q.cnt == CW'(W - 1)) begin
                div_d.run  = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done = div_q.done;
    assign quot = div_q.q;
    assign remn = div_q.r;

endmodule

// File: rtl/erase_step_plan.sv
// Chooses block or page erase for the current step and forms the device address.
module erase_step_plan #(
    parameter int W       = 24,
    parameter int SH_W    = 4,
    parameter int BLK_LOG = 3
) (
    input  logic [W-1:0]    idx,
    input  logic [W-1:0]    left,
    input  logic [SH_W-1:0] shift,
    output logic [7:0]      opcode,
    output logic [W-1:0]    step,
    output logic [23:0]     dev_addr
);
    import erase_seq_pkg::*;

    localparam int           SW       = W + (1 << SH_W);
    localparam logic [W-1:0] BLK_PGS  = W'(1 << BLK_LOG);

    logic          use_blk;
    logic [SW-1:0] wide;

    always_comb begin
        use_blk  = (idx[BLK_LOG-1:0] == '0) && (left >= BLK_PGS);
        opcode   = use_blk ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
        step     = use_blk ? BLK_PGS : W'(1);
        wide     = SW'(idx) << shift;
        dev_addr = wide[DEV_ADDR_W-1:0];
    end

endmodule

// File: rtl/erase_frame_mux.sv
// Selects the byte for the current frame position.
module erase_frame_mux (
    input  logic        is_poll,
    input  logic [1:0]  pos,
    input  logic [7:0]  opcode,
    input  logic [23:0] dev_addr,
    output logic [7:0]  byte_out,
    output logic        last
);
    import erase_seq_pkg::*;

    always_comb begin
        if (is_poll) begin
            byte_out = (pos == 2'd0) ? OP_STATUS : 8'h00;
            last     = (pos == 2'd1);
        end else begin
            case (pos)
                2'd0:    byte_out = opcode;
                2'd1:    byte_out = dev_addr[23:16];
                2'd2:    byte_out = dev_addr[15:8];
                default: byte_out = 8'h00;
            endcase
            last = (pos == 2'd3);
        end
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
    parameter int ADDR_W    = 24,
    parameter int PS_W      = 11,
    parameter int SH_W      = 4,
    parameter int GAP_W     = 16,
    parameter int BLK_PAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_len,
    input  logic [PS_W-1:0]   page_size,
    input  logic [SH_W-1:0]   page_shift,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              cs_n,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    input  logic              tx_done,
    input  logic              tx_err,
    input  logic [7:0]        rx_byte,
    output logic              done,
    output logic              err
);
    import erase_seq_pkg::*;

    localparam int BLK_LOG = $clog2(BLK_PAGES);
    localparam int N_DIV   = 2;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] left;
        logic [1:0]        pos;
        logic [GAP_W-1:0]  gap;
        logic [GAP_W-1:0]  gcfg;
        logic [SH_W-1:0]   sh;
        logic              xerr;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              div_start;
    logic [ADDR_W-1:0] dv_in   [N_DIV];
    logic [ADDR_W-1:0] dv_quot [N_DIV];
    logic [ADDR_W-1:0] dv_rem  [N_DIV];
    logic [N_DIV-1:0]  dv_done;

    assign dv_in[0] = req_addr;
    assign dv_in[1] = req_len;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        erase_div #(.W(ADDR_W), .DW(PS_W)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (div_start),
            .dividend (dv_in[g]),
            .divisor  (page_size),
            .done     (dv_done[g]),
            .quot     (dv_quot[g]),
            .remn     (dv_rem[g])
        );
    end

    logic [7:0]        plan_op;
    logic [ADDR_W-1:0] plan_step;
    logic [23:0]       plan_addr;

    erase_step_plan #(.W(ADDR_W), .SH_W(SH_W), .BLK_LOG(BLK_LOG)) u_plan (
        .idx      (seq_q.idx),
        .left     (seq_q.left),
        .shift    (seq_q.sh),
        .opcode   (plan_op),
        .step     (plan_step),
        .dev_addr (plan_addr)
    );

    erase_frame_mux u_mux (
        .is_poll  (seq_q.st == S_POLL),
        .pos      (seq_q.pos),
        .opcode   (plan_op),
        .dev_addr (plan_addr),
        .byte_out (tx_byte),
        .last     (tx_last)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        div_start  = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    div_start  = 1'b1;
                    seq_d.sh   = page_shift;
                    seq_d.gcfg = poll_gap;
                    seq_d.st   = S_DIV;
                end
            end
            S_DIV: begin
                if (&dv_done) begin
                    if ((dv_rem[0] != '0) || (dv_rem[1] != '0)) begin
                        seq_d.err = 1'b1;
                        seq_d.st  = S_IDLE;
                    end else if (dv_quot[1] == '0) begin
                        seq_d.done = 1'b1;
                        seq_d.st   = S_IDLE;
                    end else begin
                        seq_d.idx  = dv_quot[0];
                        seq_d.left = dv_quot[1];
                        seq_d.pos  = 2'd0;
                        seq_d.xerr = 1'b0;
                        seq_d.st   = S_ECMD;
                    end
                end
            end
            S_ECMD: begin
                if (tx_done) begin
                    seq_d.xerr = seq_q.xerr | tx_err;
                    if (seq_q.pos == 2'd3) begin
                        seq_d.pos = 2'd0;
                        seq_d.st  = S_SEP;
                    end else begin
                        seq_d.pos = seq_q.pos + 2'd1;
                    end
                end
            end
            S_SEP: begin
                seq_d.pos = 2'd0;
                seq_d.st  = S_POLL;
            end
            S_POLL: begin
                if (tx_done) begin
                    if (seq_q.pos == 2'd1) begin
                        seq_d.pos = 2'd0;
                        if (rx_byte[READY_BIT] && !tx_err) begin
                            seq_d.st = S_STEP;
                        end else begin
                            seq_d.gap = seq_q.gcfg;
                            seq_d.st  = S_WAIT;
                        end
                    end else begin
                        seq_d.pos = 2'd1;
                    end
                end
            end
            S_WAIT: begin
                if (seq_q.gap == '0) begin
                    seq_d.pos = 2'd0;
                    seq_d.st  = S_POLL;
                end else begin
                    seq_d.gap = seq_q.gap - 1'b1;
                end
            end
            S_STEP: begin
                seq_d.pos = 2'd0;
                if (seq_q.xerr) begin
                    seq_d.xerr = 1'b0;
                    seq_d.st   = S_ECMD;
                end else begin
                    seq_d.idx  = seq_q.idx + plan_step;
                    seq_d.left = seq_q.left - plan_step;
                    if (seq_q.left == plan_step) begin
                        seq_d.done = 1'b1;
                        seq_d.st   = S_IDLE;
                    end else begin
                        seq_d.st = S_ECMD;
                    end
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req_ready = (seq_q.st == S_IDLE);
    assign tx_valid  = (seq_q.st == S_ECMD) || (seq_q.st == S_POLL);
    assign cs_n      = !tx_valid;
    assign done      = seq_q.done;
    assign err       = seq_q.err;

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       cs_n,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       tx_last,
    input logic       tx_done,
    input logic       done,
    input logic       err
);
    logic [1:0] fpos;
    logic [7:0] fop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fpos <= 2'd0;
            fop  <= 8'h00;
        end else if (tx_valid && tx_done) begin
            if (fpos == 2'd0) fop <= tx_byte;
            fpos <= tx_last ? 2'd0 : fpos + 2'd1;
        end
    end

    AST_FIRST_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && fpos == 2'd0) |-> (tx_byte == 8'h50 || tx_byte == 8'h81 || tx_byte == 8'hD7)); // R2

    AST_ERASE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && fpos == 2'd3 && fop != 8'hD7) |-> (tx_byte == 8'h00 && tx_last)); // R3

    AST_POLL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && fpos == 2'd1 && fop == 8'hD7) |-> (tx_last && tx_byte == 8'h00)); // R4

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_done && tx_last) |=> cs_n); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready); // R9

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R1

endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cs_n      (cs_n),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .tx_last   (tx_last),
    .tx_done   (tx_done),
    .done      (done),
    .err       (err)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic [10:0] page_size = 11'd264;
    logic [3:0]  page_shift = 4'd9;
    logic [15:0] poll_gap = '0;
    logic        cs_n;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_last;
    logic        tx_done = 1'b0;
    logic        tx_err = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        done;
    logic        err;

    always #5 clk = ~clk;

    flash_erase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .page_size(page_size),
        .page_shift(page_shift), .poll_gap(poll_gap), .cs_n(cs_n),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .tx_done(tx_done), .tx_err(tx_err), .rx_byte(rx_byte),
        .done(done), .err(err)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // shifter model state
    logic [31:0] act_cmd [64];
    int act_n, byte_n, ecnt, fail_at, busy_left;
    int frame_bad, gap_viol, idle_cnt, last_stamp;
    bit check_gap, was_busy;
    logic [31:0] exp_cmd [64];
    int exp_n;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    initial begin : shifter
        int   m_pos;
        logic [7:0] m_op, byt, rx;
        logic [31:0] cur;
        bit   lst, inj;
        m_pos = 0; m_op = 0; cur = 0;
        forever begin
            @(negedge clk);
            tx_done = 1'b0;
            tx_err  = 1'b0;
            if (!tx_valid) begin
                idle_cnt++;
                continue;
            end
            if (m_pos == 0 && check_gap && idle_cnt < int'(poll_gap)) gap_viol++;
            if (m_pos == 0) check_gap = 0;
            byt = tx_byte; lst = tx_last; inj = 0; rx = 8'h00;
            byte_n++;
            if (m_pos == 0) m_op = byt;
            if (m_op == 8'hD7) begin
                if ((m_pos == 0 && lst) || (m_pos == 1 && (byt != 8'h00 || !lst)) || m_pos > 1) frame_bad++;
                if (m_pos == 1) begin
                    if (busy_left > 0) begin
                        rx = 8'h3C; busy_left--; was_busy = 1;
                    end else begin
                        rx = 8'hBC;
                    end
                end
            end else begin
                cur = {cur[23:0], byt};
                if ((m_pos == 3) != lst) frame_bad++;
                if (m_pos == 1 && ecnt == fail_at) inj = 1;
            end
            repeat (LAT) @(negedge clk);
            rx_byte = rx; tx_err = inj; tx_done = 1'b1; last_stamp = cyc;
            if (lst) begin
                if (m_op == 8'hD7) begin
                    check_gap = was_busy; was_busy = 0;
                end else begin
                    if (act_n < 64) act_cmd[act_n] = cur;
                    act_n++; ecnt++;
                    busy_left = $urandom % 4;
                end
                m_pos = 0;
            end else begin
                m_pos++;
            end
            idle_cnt = 0;
        end
    end

    task automatic build_exp(input int idx, input int pages, input int sh, input int fa);
        int k, i, p, da;
        bit blk;
        k = 0; i = idx; p = pages; exp_n = 0;
        while (p > 0) begin
            blk = (i % 8 == 0) && (p >= 8);
            da  = (i << sh) & 32'hFFFFFF;
            exp_cmd[exp_n] = {(blk ? 8'h50 : 8'h81), da[23:16], da[15:8], 8'h00};
            exp_n++;
            if (k == fa) begin
                exp_cmd[exp_n] = exp_cmd[exp_n-1];
                exp_n++;
            end
            k++;
            if (blk) begin i += 8; p -= 8; end
            else begin i += 1; p -= 1; end
        end
    endtask

    task automatic run_req(input int idx, input int pages, input int ps, input int sh,
                           input int gap, input int fa, input int mis_a, input int mis_l);
        int waitc;
        bit expect_err;
        expect_err = (mis_a != 0) || (mis_l != 0);
        act_n = 0; byte_n = 0; ecnt = 0; fail_at = fa; frame_bad = 0; gap_viol = 0;
        check_gap = 0; was_busy = 0; busy_left = 0;
        build_exp(idx, pages, sh, fa);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
        req_addr = 24'(idx * ps + mis_a);
        req_len = 24'(pages * ps + mis_l);
        page_size = 11'(ps); page_shift = 4'(sh); poll_gap = 16'(gap);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy after accept", int'(req_ready), 0);
        waitc = 0;
        while (!(done || err) && waitc < 60000) begin
            @(negedge clk);
            waitc++;
        end
        if (expect_err) begin
            chk(err == 1'b1 && done == 1'b0, "R1 misaligned gives err", int'({done, err}), 1);
            chk(byte_n == 0, "R1 no frame on reject", byte_n, 0);
        end else begin
            chk(done == 1'b1 && err == 1'b0, "R8 done result", int'({done, err}), 2);
            if (pages == 0)
                chk(byte_n == 0, "R8 zero length has no frame", byte_n, 0);
            else
                chk(cyc - last_stamp == 2, "R8 done timing", cyc - last_stamp, 2);
            chk(act_n == exp_n, "R6 R7 command count", act_n, exp_n);
            for (int j = 0; j < exp_n && j < act_n && j < 64; j++)
                chk(act_cmd[j] == exp_cmd[j], "R2 R3 R6 R7 command bytes", act_cmd[j], exp_cmd[j]);
            chk(frame_bad == 0, "R3 R4 frame shape", frame_bad, 0);
            chk(gap_viol == 0, "R5 poll gap", gap_viol, 0);
        end
        @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R8 single cycle pulse", int'({done, err}), 0);
        chk(req_ready == 1'b1, "R9 ready after finish", int'(req_ready), 1);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 195000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int ps_t [4] = '{264, 528, 1056, 256};
        int sh_t [4] = '{9, 10, 11, 8};
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && cs_n == 1'b1 && tx_valid == 1'b0, "R9 reset state",
            int'({req_ready, cs_n, tx_valid}), 6);
        chk(done == 1'b0 && err == 1'b0, "R8 reset outputs", int'({done, err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed cases
        run_req(0, 8, 264, 9, 2, -1, 0, 0);    // R2 single block
        run_req(7, 9, 528, 10, 1, -1, 0, 0);   // R2 page then block
        run_req(8, 7, 264, 9, 0, -1, 0, 0);    // R2 short tail, pages only
        run_req(0, 0, 264, 9, 0, -1, 0, 0);    // R8 zero length
        run_req(3, 2, 264, 9, 0, -1, 5, 0);    // R1 misaligned address
        run_req(3, 2, 1056, 11, 0, -1, 0, 17); // R1 misaligned length
        run_req(8200, 3, 1056, 11, 3, -1, 0, 0); // R3 address truncation
        run_req(16, 10, 256, 8, 4, 0, 0, 0);   // R7 failure on first step
        run_req(5, 12, 528, 10, 0, 4, 0, 0);   // R7 failure on later step
        // constrained random
        for (int t = 0; t < 24; t++) begin
            int sel, idx, pages, gap, fa, ma;
            sel = $urandom % 4;
            idx = $urandom % 40;
            pages = $urandom % 18;
            gap = $urandom % 5;
            fa = ($urandom % 3 == 0) ? int'($urandom % (pages + 1)) : -1;
            ma = ($urandom % 6 == 0) ? 1 + int'($urandom % (ps_t[sel] - 1)) : 0;
            run_req(idx, pages, ps_t[sel], sh_t[sel], gap, fa, ma, 0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule